// File: doc/BRIEF.md
# Watchdog Timer with Selectable Expiry Event

This block is a register-mapped watchdog. Software loads a timeout into a count register, enables the block and then services it at regular intervals. Each service restarts a down-counter from that timeout. If software stops servicing it, for example because a task hangs, the counter reaches zero. The block then records the expiry in a sticky flag and emits one configurable event. The event can be a reset request, a non-maskable interrupt, a general interrupt, or nothing at all.

The block is disabled by a magic key held in the control register. Any other key value lets it count, so a control write of all zeros starts it with the reset event selected. The register port is a single-cycle write strobe with an address and write data. The read data is a combinational function of the address.

Top module: `guard_timer`

## Requirements
- R1: After reset the control register reads 0x00000AD0 (disable key present, event select 00, flag clear). The count register and the status counter read 0, and all event outputs and `expired_o` are low.
- R2: The block counts only while control bits 11:4 differ from 0xAD. While they hold 0xAD the status counter keeps its value. A control write of 0x0000 enables counting with the reset event selected.
- R3: Addresses are 0 for control, 1 for count and 2 for status. Address 3 has no register and reads 0. A read of status returns the current counter value. While the block is enabled and running, the counter falls by one on each clock edge.
- R4: An expiry happens at a clock edge where the block was enabled, was not stopped, the counter was zero and no reload occurred. At that edge exactly one of `rst_req_o`, `nmi_o` and `irq_o` rises for one cycle, chosen by control bits 2:1 as held before the edge: 00 gives reset, 01 non-maskable, 10 general, and 11 gives none.
- R5: On expiry, control bit 15 (`expired_o`) sets. The counter then stays at zero with no further event until a service or a disabled cycle.
- R6: Any write to status reloads the counter from the count register and restarts counting. A service landing on the expiry edge suppresses that expiry.
- R7: A write to the count register while enabled is ignored. While disabled, it stores the value and also preloads the status counter.
- R8: A control write with bit 15 set clears the flag, and one with bit 15 clear leaves it unchanged. If a clear and an expiry fall on the same edge, the flag ends set.
- R9: Control reads back as {bit 15 flag, bits 11:4 key, bits 2:1 select}, with all other bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; one counter tick per edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address for reads and writes |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` |
| rst_req_o | output | 1 | One-cycle reset request on expiry |
| nmi_o | output | 1 | One-cycle non-maskable interrupt on expiry |
| irq_o | output | 1 | One-cycle general interrupt on expiry |
| expired_o | output | 1 | Sticky expiry flag (control bit 15) |

## Verification
The bench builds the block with a 10-bit counter and timeouts of 3 and 5 ticks. With these values every event selection, the stop after expiry, and the exact-edge races can each be reached within a few dozen cycles. The two races are a service on the expiry edge and a flag clear on the expiry edge. The 32-bit default would take 2^32 ticks to reach zero from a full count. The narrow counter keeps the same field positions and the same disable key.

// File: rtl/guard_timer_pkg.sv
package guard_timer_pkg;

    typedef enum logic [1:0] {
        EV_RESET = 2'b00,
        EV_NMI   = 2'b01,
        EV_IRQ   = 2'b10,
        EV_NONE  = 2'b11
    } ev_sel_e;

    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_PERIOD = 2'd1;
    localparam logic [1:0] ADDR_STATUS = 2'd2;

    localparam int BUS_W = 32;

endpackage

// File: rtl/guard_timer_regs.sv
module guard_timer_regs
    import guard_timer_pkg::*;
#(
    parameter int          CNT_W       = 32,
    parameter logic [7:0]  DISABLE_KEY = 8'hAD
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_i,
    input  logic [1:0]        addr_i,
    input  logic [BUS_W-1:0]  wdata_i,
    input  logic              expire_i,
    output logic              enable_o,
    output ev_sel_e           sel_o,
    output logic              flag_o,
    output logic [7:0]        key_o,
    output logic [CNT_W-1:0]  period_o,
    output logic              load_o,
    output logic [CNT_W-1:0]  load_val_o
);

    typedef struct packed {
        logic [7:0]       key;
        ev_sel_e          sel;
        logic             flag;
        logic [CNT_W-1:0] period;
    } regs_t;

    regs_t st_d, st_q;
    logic  load_d;
    logic [CNT_W-1:0] load_val_d;

    assign enable_o = (st_q.key != DISABLE_KEY);

    always_comb begin
        st_d       = st_q;
        load_d     = 1'b0;
        load_val_d = st_q.period;
        if (wr_i) begin
            unique case (addr_i)
                ADDR_CTRL: begin
                    st_d.key = wdata_i[11:4];
                    st_d.sel = ev_sel_e'(wdata_i[2:1]);
                    if (wdata_i[15]) st_d.flag = 1'b0;
                end
                ADDR_PERIOD: begin
                    if (!enable_o) begin
                        st_d.period = wdata_i[CNT_W-1:0];
                        load_d      = 1'b1;
                        load_val_d  = wdata_i[CNT_W-1:0];
                    end
                end
                ADDR_STATUS: begin
                    load_d     = 1'b1;
                    load_val_d = st_q.period;
                end
                default: ;
            endcase
        end
        if (expire_i) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.key    <= DISABLE_KEY;
            st_q.sel    <= EV_RESET;
            st_q.flag   <= 1'b0;
            st_q.period <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_o      = st_q.sel;
    assign flag_o     = st_q.flag;
    assign key_o      = st_q.key;
    assign period_o   = st_q.period;
    assign load_o     = load_d;
    assign load_val_o = load_val_d;

    // R7: count register is locked while the block is enabled
    assert_period_locked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && addr_i == ADDR_PERIOD && enable_o) |=> $stable(period_o));

    // R8: an expiry always leaves the flag set
    assert_flag_sets_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        expire_i |=> flag_o);

endmodule

// File: rtl/guard_timer_count.sv
module guard_timer_count #(
    parameter int CNT_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             enable_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             expire_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             halt;
    } cnt_t;

    cnt_t st_d, st_q;
    logic expire;

    always_comb begin
        st_d   = st_q;
        expire = enable_i && !st_q.halt && (st_q.cnt == '0) && !load_i;
        if (load_i) begin
            st_d.cnt  = load_val_i;
            st_d.halt = 1'b0;
        end else if (!enable_i) begin
            st_d.halt = 1'b0;
        end else if (expire) begin
            st_d.halt = 1'b1;
        end else if (!st_q.halt) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o    = st_q.cnt;
    assign expire_o = expire;

    // R3: a running counter falls by exactly one per edge
    assert_decrement_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (enable_i && !st_q.halt && st_q.cnt != '0 && !load_i)
        |=> cnt_o == $past(cnt_o) - 1'b1);

    // R5: after expiry the counter sits at zero
    assert_stop_at_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        expire_o |=> (cnt_o == '0) && !expire_o);

endmodule

// File: rtl/guard_timer_event.sv
module guard_timer_event
    import guard_timer_pkg::*;
(
    input  logic    clk_i,
    input  logic    rst_ni,
    input  logic    expire_i,
    input  ev_sel_e sel_i,
    output logic    rst_req_o,
    output logic    nmi_o,
    output logic    irq_o
);

    typedef struct packed {
        logic rst_req;
        logic nmi;
        logic irq;
    } ev_t;

    ev_t st_d, st_q;

    always_comb begin
        st_d.rst_req = expire_i && (sel_i == EV_RESET);
        st_d.nmi     = expire_i && (sel_i == EV_NMI);
        st_d.irq     = expire_i && (sel_i == EV_IRQ);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rst_req_o = st_q.rst_req;
    assign nmi_o     = st_q.nmi;
    assign irq_o     = st_q.irq;

    // R4: at most one event line at a time
    assert_one_event_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({rst_req_o, nmi_o, irq_o}));

    // R4: events are single-cycle pulses
    assert_pulse_width_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rst_req_o || nmi_o || irq_o) |=> !(rst_req_o || nmi_o || irq_o));

endmodule

// File: rtl/guard_timer.sv
module guard_timer
    import guard_timer_pkg::*;
#(
    parameter int         CNT_W       = 32,
    parameter logic [7:0] DISABLE_KEY = 8'hAD
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        bus_wr_i,
    input  logic [1:0]  bus_addr_i,
    input  logic [31:0] bus_wdata_i,
    output logic [31:0] bus_rdata_o,
    output logic        rst_req_o,
    output logic        nmi_o,
    output logic        irq_o,
    output logic        expired_o
);

    localparam int PAD_W = BUS_W - CNT_W;

    logic             enable;
    ev_sel_e          sel;
    logic             flag;
    logic [7:0]       key;
    logic [CNT_W-1:0] period;
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] cnt;
    logic             expire;

    guard_timer_regs #(.CNT_W(CNT_W), .DISABLE_KEY(DISABLE_KEY)) u_regs (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_i       (bus_wr_i),
        .addr_i     (bus_addr_i),
        .wdata_i    (bus_wdata_i),
        .expire_i   (expire),
        .enable_o   (enable),
        .sel_o      (sel),
        .flag_o     (flag),
        .key_o      (key),
        .period_o   (period),
        .load_o     (load),
        .load_val_o (load_val)
    );

    guard_timer_count #(.CNT_W(CNT_W)) u_count (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .enable_i   (enable),
        .load_i     (load),
        .load_val_i (load_val),
        .cnt_o      (cnt),
        .expire_o   (expire)
    );

    guard_timer_event u_event (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .expire_i  (expire),
        .sel_i     (sel),
        .rst_req_o (rst_req_o),
        .nmi_o     (nmi_o),
        .irq_o     (irq_o)
    );

    logic [BUS_W-1:0] period_ext, cnt_ext;

    generate
        if (PAD_W > 0) begin : g_pad
            assign period_ext = {{PAD_W{1'b0}}, period};
            assign cnt_ext    = {{PAD_W{1'b0}}, cnt};
        end else begin : g_nopad
            assign period_ext = period;
            assign cnt_ext    = cnt;
        end
    endgenerate

    always_comb begin
        unique case (bus_addr_i)
            ADDR_CTRL:   bus_rdata_o = {16'h0000, flag, 3'b000, key, 1'b0, sel, 1'b0};
            ADDR_PERIOD: bus_rdata_o = period_ext;
            ADDR_STATUS: bus_rdata_o = cnt_ext;
            default:     bus_rdata_o = '0;
        endcase
    end

    assign expired_o = flag;

    // R5: any event pulse coincides with the sticky flag
    assert_event_flags_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rst_req_o || nmi_o || irq_o) |-> expired_o);

    // R6: a service restarts from the count register value
    assert_service_reload_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_wr_i && bus_addr_i == ADDR_STATUS) |=> (cnt == $past(period)) && !rst_req_o && !nmi_o && !irq_o);

endmodule

// File: tb/guard_timer_tb.sv
module guard_timer_tb;

    localparam int CNT_W = 10;
    localparam int MASK  = (1 << CNT_W) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0;
    logic [1:0]  addr = 2'd2;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rst_req, nmi, irq, expired;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    // reference model state
    int m_key = 8'hAD, m_sel = 0, m_flag = 0, m_period = 0, m_cnt = 0, m_halt = 0;
    int m_rst = 0, m_nmi = 0, m_irq = 0;

    always #10 clk = ~clk;

    guard_timer #(.CNT_W(CNT_W)) u_dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .bus_wr_i    (wr),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .rst_req_o   (rst_req),
        .nmi_o       (nmi),
        .irq_o       (irq),
        .expired_o   (expired)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_key = 8'hAD; m_sel = 0; m_flag = 0; m_period = 0; m_cnt = 0; m_halt = 0;
            m_rst = 0; m_nmi = 0; m_irq = 0;
        end else begin
            int en, ld, lv, fire;
            en = (m_key != 8'hAD);
            ld = 0; lv = 0;
            if (wr && addr == 2) begin ld = 1; lv = m_period; end
            if (wr && addr == 1 && en == 0) begin
                ld = 1; lv = wdata & MASK; m_period = lv;
            end
            fire = (en != 0) && (m_halt == 0) && (m_cnt == 0) && (ld == 0);
            m_rst = fire && (m_sel == 0);
            m_nmi = fire && (m_sel == 1);
            m_irq = fire && (m_sel == 2);
            if (wr && addr == 0) begin
                m_key = (wdata >> 4) & 8'hFF;
                m_sel = (wdata >> 1) & 3;
                if (wdata[15]) m_flag = 0;
            end
            if (fire) m_flag = 1;
            if (ld) begin m_cnt = lv; m_halt = 0; end
            else if (!en) m_halt = 0;
            else if (fire) m_halt = 1;
            else if (!m_halt) m_cnt = (m_cnt - 1) & MASK;
        end
    end

    function automatic logic [31:0] model_read(input logic [1:0] a);
        case (a)
            2'd0: model_read = 32'(m_flag << 15) | 32'(m_key << 4) | 32'(m_sel << 1);
            2'd1: model_read = 32'(m_period);
            2'd2: model_read = 32'(m_cnt);
            default: model_read = 32'd0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the reference model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R4 rst_req", 32'(rst_req), 32'(m_rst));
            check("R4 nmi",     32'(nmi),     32'(m_nmi));
            check("R4 irq",     32'(irq),     32'(m_irq));
            check("R5 expired", 32'(expired), 32'(m_flag));
            check(addr == 0 ? "R9 ctrl read" : addr == 1 ? "R7 count read" : "R3 read",
                  rdata, model_read(addr));
        end
    end

    task automatic op(input logic w, input logic [1:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        wr = w; addr = a; wdata = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) op(1'b0, 2'd2, 32'd0);
    endtask

    task automatic peek(input string req, input logic [1:0] a, input logic [31:0] exp);
        op(1'b0, a, 32'd0);
        @(negedge clk); #1;
        check(req, rdata, exp);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R1 reset state
        peek("R1 ctrl", 2'd0, 32'h0000_0AD0);
        peek("R1 status", 2'd2, 32'd0);
        peek("R1 count", 2'd1, 32'd0);
        check("R1 expired", 32'(expired), 32'd0);
        peek("R3 unmapped", 2'd3, 32'd0);
        // R7 preload while disabled
        op(1'b1, 2'd1, 32'd5);
        peek("R7 preload", 2'd2, 32'd5);
        idle(3);
        peek("R2 held while disabled", 2'd2, 32'd5);
        // R2 enable by zero write, reset event
        op(1'b1, 2'd0, 32'h0000_0000);
        idle(10);
        peek("R5 flag after expiry", 2'd0, 32'h0000_8000);
        peek("R5 stopped at zero", 2'd2, 32'd0);
        // R7 ignored while enabled
        op(1'b1, 2'd1, 32'd9);
        peek("R7 ignored", 2'd1, 32'd5);
        // R8 clear flag, select nmi
        op(1'b1, 2'd0, 32'h0000_8002);
        peek("R8 cleared", 2'd0, 32'h0000_0002);
        peek("R5 still stopped", 2'd2, 32'd0);
        op(1'b1, 2'd2, 32'd0);
        idle(8);
        // R6 service on the expiry edge
        op(1'b1, 2'd0, 32'h0000_8002);
        op(1'b1, 2'd2, 32'd0);
        idle(5);
        op(1'b1, 2'd2, 32'd0);
        idle(2);
        peek("R6 tie suppressed expiry", 2'd0, 32'h0000_0002);
        for (int k = 0; k < 3; k++) begin
            idle(2);
            op(1'b1, 2'd2, 32'd0);
        end
        peek("R6 steady service", 2'd0, 32'h0000_0002);
        idle(6);
        // R4 general interrupt, then no event
        op(1'b1, 2'd0, 32'h0000_8004);
        op(1'b1, 2'd2, 32'd0);
        idle(8);
        op(1'b1, 2'd0, 32'h0000_8006);
        op(1'b1, 2'd2, 32'd0);
        idle(8);
        peek("R4 no-event select still flags", 2'd0, 32'h0000_8006);
        // R8 write-one-to-clear semantics
        op(1'b1, 2'd0, 32'h0000_0AD6);
        peek("R8 zero leaves flag", 2'd0, 32'h0000_8AD6);
        op(1'b1, 2'd0, 32'h0000_8AD6);
        peek("R8 one clears flag", 2'd0, 32'h0000_0AD6);
        op(1'b1, 2'd1, 32'd3);
        idle(4);
        peek("R2 disabled holds preload", 2'd2, 32'd3);
        // R8 set wins over clear on the same edge
        op(1'b1, 2'd0, 32'h0000_8000);
        idle(3);
        op(1'b1, 2'd0, 32'h0000_8000);
        peek("R8 set beats clear", 2'd0, 32'h0000_8000);
        idle(3);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule